// File: doc/BRIEF.md
# SMBus Packet Error Code Unit

This block keeps the CRC-8 packet error code over the bytes of an SMBus transfer. The serial engine next to it presents each byte with a one-cycle valid strobe, a direction flag (transmit or receive) and an end-of-packet strobe. A 2-bit control input picks one of four modes: off, calculate only, auto-append, or clear.

In calculate-only mode the running value is copied to the calculated-CRC output at end of packet, in either direction. In auto-append mode on transmit, the block raises a one-cycle append request carrying the CRC byte for the engine to send. It also copies that value to the calculated-CRC output and then clears its calculator. In auto-append mode on receive, the last byte of the packet is taken as the received PEC. At end of packet the CRC over the preceding bytes goes to the calculated-CRC output and the received PEC goes to the received-CRC output. Because the running CRC also folds in the received PEC, a clean frame leaves it at zero, and a flag reports this for the ACK/NACK decision.

A host issues the clear command before each new frame.

Top module: `smbus_pec_unit`

## Requirements
- R1: Every byte accepted in calculate-only (code 2'b10) or auto-append (code 2'b01) mode updates the running CRC once. The update uses polynomial x^8+x^2+x+1 (0x07), MSB first, with a start value of 0x00. The nine ASCII bytes "123456789" give 0xF4.
- R2: In off mode (code 2'b00), bytes and end-of-packet strobes are ignored. The running CRC, both result outputs and the append request all stay unchanged.
- R3: The clear code 2'b11 sets the running CRC to 0x00 on the next edge and drops any append arming. The calculated-CRC and received-CRC outputs are left as they were.
- R4: In calculate-only mode, an end-of-packet strobe copies the running CRC to `calc_crc` for both directions. If a byte arrives in the same cycle as the strobe, that byte is included. No append is requested and the running CRC is not cleared.
- R5: In auto-append mode on transmit (`dir_tx`=1), an armed end-of-packet strobe makes `append_req` high for exactly one cycle after the edge. `append_byte` and `calc_crc` both equal the CRC over all data bytes, including a byte given with the strobe. The running CRC is 0x00 in that same cycle.
- R6: Auto-append is armed only when at least one data byte has been accepted in auto-append mode since the last clear or append; the byte given with the strobe counts. An unarmed transmit strobe in auto-append mode behaves as in R4.
- R7: In auto-append mode on receive (`dir_tx`=0), the last accepted byte is the received PEC. At end of packet, `rcvd_crc` takes that byte and `calc_crc` takes the CRC of the bytes before it. The result is the same whether the strobe comes with the PEC byte or in a later cycle.
- R8: `crc_zero` is 1 exactly when the running CRC is 0x00, one cycle after the byte that sets it. After a receive frame whose PEC is correct, it reads 1.
- R9: After reset, `calc_crc`, `rcvd_crc` and `append_byte` are 0x00, `append_req` is 0 and `crc_zero` is 1.
- R10: When the clear code and a valid byte come in the same cycle, the clear wins and the byte is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pec_ctl | input | 2 | Mode: 00 off, 10 calculate, 01 auto-append, 11 clear |
| dir_tx | input | 1 | 1 for transmit, 0 for receive |
| byte_vld | input | 1 | Byte strobe, one cycle per byte |
| byte_data | input | 8 | Byte on the bus |
| eop | input | 1 | End-of-packet strobe |
| calc_crc | output | 8 | Captured calculated CRC |
| rcvd_crc | output | 8 | Captured received PEC byte |
| append_req | output | 1 | One-cycle request to transmit `append_byte` |
| append_byte | output | 8 | CRC byte to append |
| crc_zero | output | 1 | Running CRC equals zero |

## Verification
The last byte of a packet and the end-of-packet strobe can arrive in the same cycle. In that case the byte must be folded in, or on receive singled out as the PEC, at the same edge that captures the results and, on transmit, fires the append and clears the calculator. The table-driven packets therefore end on that coincidence, and their captured values are compared with a separate long-division model. Directed packets give the strobe a cycle after the last byte and expect identical results. A further case places a clear on the same cycle as a byte and checks that a later capture excludes that byte.

// File: rtl/smbus_pec_pkg.sv
// Shared definitions for the PEC unit: control codes and the CRC byte step.
// Assumes 8-bit bytes and an 8-bit CRC, shifted MSB first.
package smbus_pec_pkg;

    localparam int PEC_W  = 8;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        PEC_OFF    = 2'b00,
        PEC_APPEND = 2'b01,
        PEC_CALC   = 2'b10,
        PEC_CLEAR  = 2'b11
    } pec_mode_e;

    // Fold one byte into the CRC, MSB first, with the given polynomial.
    function automatic logic [PEC_W-1:0] pec_step(
        input logic [PEC_W-1:0]  crc_in,
        input logic [BYTE_W-1:0] data_in,
        input logic [PEC_W-1:0]  poly
    );
        logic [PEC_W-1:0] acc;
        logic             fb;
        acc = crc_in;
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            fb  = acc[PEC_W-1] ^ data_in[i];
            acc = {acc[PEC_W-2:0], 1'b0} ^ (fb ? poly : '0);
        end
        return acc;
    endfunction

endpackage

// File: rtl/pec_crc_core.sv
// Running CRC register with the clear command and a self-clear input.
// It also keeps the value before the most recent byte and that byte,
// so a receive capture can separate off the trailing PEC byte.
// Assumes byte_vld is a single-cycle strobe.
module pec_crc_core
    import smbus_pec_pkg::*;
#(
    parameter logic [PEC_W-1:0] POLY     = 8'h07,
    parameter logic [PEC_W-1:0] INIT     = 8'h00,
    parameter bit               ZERO_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pec_mode_e         mode,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              self_clr,
    output logic              take,
    output logic [PEC_W-1:0]  crc_q,
    output logic [PEC_W-1:0]  crc_next,
    output logic [PEC_W-1:0]  crc_prev_q,
    output logic [BYTE_W-1:0] last_byte_q,
    output logic              zero
);

    logic             running;
    logic [PEC_W-1:0] crc_d;

    // Decide whether a byte is accepted and what the CRC becomes.
    always_comb begin
        running  = (mode == PEC_CALC) || (mode == PEC_APPEND);
        take     = byte_vld && running;
        crc_next = take ? pec_step(crc_q, byte_data, POLY) : crc_q;
        if ((mode == PEC_CLEAR) || self_clr)
            crc_d = INIT;
        else
            crc_d = crc_next;
    end

    // Running CRC register.
    always_ff @(posedge clk) begin
        if (!rst_n) crc_q <= INIT;
        else        crc_q <= crc_d;
    end

    // Remember the CRC before the latest byte, and the byte itself.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_prev_q  <= INIT;
            last_byte_q <= '0;
        end else if (mode == PEC_CLEAR) begin
            crc_prev_q  <= INIT;
            last_byte_q <= '0;
        end else if (take) begin
            crc_prev_q  <= crc_q;
            last_byte_q <= byte_data;
        end
    end

    // Zero flag: registered alongside the CRC, or decoded from it.
    generate
        if (ZERO_REG) begin : g_zero_reg
            logic zero_q;
            // Register the zero test of the next CRC value.
            always_ff @(posedge clk) begin
                if (!rst_n) zero_q <= (INIT == '0);
                else        zero_q <= (crc_d == '0);
            end
            assign zero = zero_q;
        end else begin : g_zero_comb
            assign zero = (crc_q == '0);
        end
    endgenerate

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PEC_CLEAR) |=> (crc_q == INIT));
    p_hold_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PEC_OFF) |=> $stable(crc_q));
    p_zero_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        zero == (crc_q == '0));
    p_clear_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PEC_CLEAR && byte_vld) |=> $stable(last_byte_q) || last_byte_q == '0);

endmodule

// File: rtl/pec_append_ctl.sv
// Arming and firing of the transmit auto-append. It fires on an
// end-of-packet strobe in auto-append mode on transmit, once at least
// one byte has been accepted in that mode since the last clear or append.
module pec_append_ctl
    import smbus_pec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  pec_mode_e        mode,
    input  logic             dir_tx,
    input  logic             eop,
    input  logic             take,
    input  logic [PEC_W-1:0] crc_next,
    output logic             fire,
    output logic             append_req,
    output logic [PEC_W-1:0] append_byte
);

    logic armed_q;

    // Fire when the strobe meets an armed transmit in auto-append mode.
    always_comb begin
        fire = eop && dir_tx && (mode == PEC_APPEND) && (armed_q || take);
    end

    // Arm on a byte taken in auto-append mode; disarm on clear, off or append.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b0;
        else if (fire || mode == PEC_CLEAR || mode == PEC_OFF)
            armed_q <= 1'b0;
        else if (take && mode == PEC_APPEND)
            armed_q <= 1'b1;
    end

    // One-cycle request carrying the CRC byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            append_req  <= 1'b0;
            append_byte <= '0;
        end else begin
            append_req <= fire;
            if (fire) append_byte <= crc_next;
        end
    end

    p_one_shot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        append_req |=> !append_req);
    p_no_append_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != PEC_APPEND) |=> !append_req);
    p_unarmed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_q && !take) |=> !append_req);

endmodule

// File: rtl/pec_capture.sv
// Result registers loaded at end of packet. Transmit and calculate-only
// captures take the running CRC including a same-cycle byte. A receive
// capture in auto-append mode sets apart the last byte as the received PEC.
module pec_capture
    import smbus_pec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  pec_mode_e         mode,
    input  logic              dir_tx,
    input  logic              eop,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic [PEC_W-1:0]  crc_q,
    input  logic [PEC_W-1:0]  crc_next,
    input  logic [PEC_W-1:0]  crc_prev_q,
    input  logic [BYTE_W-1:0] last_byte_q,
    output logic [PEC_W-1:0]  calc_crc,
    output logic [BYTE_W-1:0] rcvd_crc
);

    logic rx_split;
    logic cap;

    // Classify the capture.
    always_comb begin
        cap      = eop && ((mode == PEC_CALC) || (mode == PEC_APPEND));
        rx_split = cap && !dir_tx && (mode == PEC_APPEND);
    end

    // Load the result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            calc_crc <= '0;
            rcvd_crc <= '0;
        end else if (rx_split) begin
            calc_crc <= byte_vld ? crc_q : crc_prev_q;
            rcvd_crc <= byte_vld ? byte_data : last_byte_q;
        end else if (cap) begin
            calc_crc <= crc_next;
        end
    end

    p_keep_no_eop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !eop |=> ($stable(calc_crc) && $stable(rcvd_crc)));
    p_rcvd_only_rx_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_split |=> $stable(rcvd_crc));

endmodule

// File: rtl/smbus_pec_unit.sv
// Top of the SMBus PEC unit: ties together the CRC core, the append
// control and the result capture. The bit engine supplies byte, direction
// and end-of-packet strobes and sends append_byte when append_req is high.
module smbus_pec_unit
    import smbus_pec_pkg::*;
#(
    parameter logic [PEC_W-1:0] POLY     = 8'h07,
    parameter logic [PEC_W-1:0] INIT     = 8'h00,
    parameter bit               ZERO_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        pec_ctl,
    input  logic              dir_tx,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              eop,
    output logic [PEC_W-1:0]  calc_crc,
    output logic [BYTE_W-1:0] rcvd_crc,
    output logic              append_req,
    output logic [PEC_W-1:0]  append_byte,
    output logic              crc_zero
);

    pec_mode_e         mode;
    logic              take;
    logic              fire;
    logic [PEC_W-1:0]  crc_q;
    logic [PEC_W-1:0]  crc_next;
    logic [PEC_W-1:0]  crc_prev_q;
    logic [BYTE_W-1:0] last_byte_q;

    assign mode = pec_mode_e'(pec_ctl);

    pec_crc_core #(.POLY(POLY), .INIT(INIT), .ZERO_REG(ZERO_REG)) u_core (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .byte_vld(byte_vld), .byte_data(byte_data), .self_clr(fire),
        .take(take), .crc_q(crc_q), .crc_next(crc_next),
        .crc_prev_q(crc_prev_q), .last_byte_q(last_byte_q), .zero(crc_zero)
    );

    pec_append_ctl u_append (
        .clk(clk), .rst_n(rst_n), .mode(mode), .dir_tx(dir_tx), .eop(eop),
        .take(take), .crc_next(crc_next), .fire(fire),
        .append_req(append_req), .append_byte(append_byte)
    );

    pec_capture u_capture (
        .clk(clk), .rst_n(rst_n), .mode(mode), .dir_tx(dir_tx), .eop(eop),
        .byte_vld(byte_vld), .byte_data(byte_data), .crc_q(crc_q),
        .crc_next(crc_next), .crc_prev_q(crc_prev_q),
        .last_byte_q(last_byte_q), .calc_crc(calc_crc), .rcvd_crc(rcvd_crc)
    );

    p_append_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        append_req |-> (crc_q == INIT));
    p_append_matches_r5: assert property (@(posedge clk) disable iff (!rst_n)
        append_req |-> (calc_crc == append_byte));

endmodule

// File: tb/sim_smbus_pec_unit.sv
module sim_smbus_pec_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pec_ctl = 2'b00;
    logic       dir_tx = 1'b0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       eop = 1'b0;
    logic [7:0] calc_crc, rcvd_crc, append_byte;
    logic       append_req, crc_zero;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    smbus_pec_unit u0 (
        .clk(clk), .rst_n(rst_n), .pec_ctl(pec_ctl), .dir_tx(dir_tx),
        .byte_vld(byte_vld), .byte_data(byte_data), .eop(eop),
        .calc_crc(calc_crc), .rcvd_crc(rcvd_crc), .append_req(append_req),
        .append_byte(append_byte), .crc_zero(crc_zero)
    );

    // Packet table: [39:38] mode, [37] tx, [36] good PEC, [35:33] count, [31:0] bytes.
    localparam logic [39:0] VECS [8] = '{
        {2'b10, 1'b1, 1'b0, 3'd3, 1'b0, 32'h01020300},
        {2'b10, 1'b0, 1'b0, 3'd2, 1'b0, 32'hFF800000},
        {2'b01, 1'b1, 1'b0, 3'd4, 1'b0, 32'hDEADBEEF},
        {2'b01, 1'b1, 1'b0, 3'd1, 1'b0, 32'h5A000000},
        {2'b01, 1'b0, 1'b1, 3'd3, 1'b0, 32'h10203000},
        {2'b01, 1'b0, 1'b0, 3'd2, 1'b0, 32'hC3A50000},
        {2'b10, 1'b1, 1'b0, 3'd4, 1'b0, 32'h12345678},
        {2'b01, 1'b0, 1'b1, 3'd1, 1'b0, 32'h00000000}
    };

    // Reference CRC step by long division with x^8+x^2+x+1.
    function automatic logic [7:0] ref_step(input logic [7:0] c, input logic [7:0] d);
        logic [15:0] w;
        w = {c ^ d, 8'h00};
        for (int k = 15; k >= 8; k--)
            if (w[k]) w[k-8 +: 9] = w[k-8 +: 9] ^ 9'h107;
        return w[7:0];
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Drive one cycle from a negedge to the next negedge.
    task automatic cyc(input logic v, input logic [7:0] b, input logic e);
        byte_vld = v; byte_data = b; eop = e;
        @(negedge clk);
        byte_vld = 1'b0; eop = 1'b0;
    endtask

    task automatic clear_calc();
        pec_ctl = 2'b11;
        cyc(1'b0, 8'h00, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] crc, pec, str [9];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        check("R9 calc", calc_crc, 8'h00);
        check("R9 rcvd", rcvd_crc, 8'h00);
        check("R9 abyte", append_byte, 8'h00);
        check("R9 areq", {7'b0, append_req}, 8'h00);
        check("R9 zero", {7'b0, crc_zero}, 8'h01);

        // Table walk: R1, R4, R5, R7, R8
        foreach (VECS[vi]) begin
            logic [1:0] md;
            logic tx, good, rx_app;
            int n;
            md = VECS[vi][39:38]; tx = VECS[vi][37]; good = VECS[vi][36];
            n = int'(VECS[vi][35:33]);
            rx_app = (md == 2'b01) && !tx;
            dir_tx = tx;
            clear_calc();
            pec_ctl = md;
            crc = 8'h00;
            for (int i = 0; i < n; i++) begin
                logic [7:0] b;
                b = VECS[vi][31 - 8*i -: 8];
                crc = ref_step(crc, b);
                cyc(1'b1, b, (i == n - 1) && !rx_app);
            end
            if (rx_app) begin
                pec = good ? crc : (crc ^ 8'h01);
                cyc(1'b1, pec, 1'b1);
                check("R7 calc", calc_crc, crc);
                check("R7 rcvd", rcvd_crc, pec);
                check("R8 zero", {7'b0, crc_zero}, {7'b0, good});
            end else if (md == 2'b01) begin
                check("R5 areq", {7'b0, append_req}, 8'h01);
                check("R5 abyte", append_byte, crc);
                check("R5 calc", calc_crc, crc);
                check("R5 cleared", {7'b0, crc_zero}, 8'h01);
                cyc(1'b0, 8'h00, 1'b0);
                check("R5 one cycle", {7'b0, append_req}, 8'h00);
            end else begin
                check("R4 calc", calc_crc, crc);
                check("R4 no append", {7'b0, append_req}, 8'h00);
                check("R8 zero", {7'b0, crc_zero}, {7'b0, crc == 8'h00});
            end
        end

        // R1 standard check string
        str = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
        dir_tx = 1'b1;
        clear_calc();
        pec_ctl = 2'b10;
        for (int i = 0; i < 9; i++) cyc(1'b1, str[i], i == 8);
        check("R1 check value", calc_crc, 8'hF4);

        // R2 off mode ignores bytes and strobes
        clear_calc();
        pec_ctl = 2'b00;
        cyc(1'b1, 8'hAA, 1'b0);
        cyc(1'b1, 8'h55, 1'b1);
        check("R2 calc kept", calc_crc, 8'hF4);
        check("R2 no append", {7'b0, append_req}, 8'h00);
        check("R2 zero kept", {7'b0, crc_zero}, 8'h01);
        pec_ctl = 2'b10;
        cyc(1'b1, 8'h01, 1'b1);
        check("R2 bytes skipped", calc_crc, 8'h07);

        // R3 clear keeps results, zeroes running CRC
        cyc(1'b1, 8'h55, 1'b0);
        check("R3 nonzero before", {7'b0, crc_zero}, 8'h00);
        clear_calc();
        check("R3 zero after", {7'b0, crc_zero}, 8'h01);
        check("R3 calc kept", calc_crc, 8'h07);

        // R10 clear beats a same-cycle byte
        pec_ctl = 2'b11;
        cyc(1'b1, 8'h01, 1'b0);
        pec_ctl = 2'b10;
        cyc(1'b0, 8'h00, 1'b1);
        check("R10 byte dropped", calc_crc, 8'h00);

        // R6 auto-append selected only at the strobe: not armed
        dir_tx = 1'b1;
        clear_calc();
        pec_ctl = 2'b10;
        cyc(1'b1, 8'h01, 1'b0);
        pec_ctl = 2'b01;
        cyc(1'b0, 8'h00, 1'b1);
        check("R6 no append", {7'b0, append_req}, 8'h00);
        check("R6 calc", calc_crc, 8'h07);

        // R6 armed by an earlier byte: strobe in a later cycle appends
        clear_calc();
        pec_ctl = 2'b01;
        cyc(1'b1, 8'h01, 1'b0);
        cyc(1'b0, 8'h00, 1'b1);
        check("R6 armed append", {7'b0, append_req}, 8'h01);
        check("R6 armed byte", append_byte, 8'h07);

        // R7 receive with strobe one cycle after the PEC byte
        dir_tx = 1'b0;
        clear_calc();
        pec_ctl = 2'b01;
        crc = ref_step(ref_step(8'h00, 8'h3C), 8'h99);
        cyc(1'b1, 8'h3C, 1'b0);
        cyc(1'b1, 8'h99, 1'b0);
        cyc(1'b1, crc, 1'b0);
        cyc(1'b0, 8'h00, 1'b1);
        check("R7 late calc", calc_crc, crc);
        check("R7 late rcvd", rcvd_crc, crc);
        check("R8 good frame", {7'b0, crc_zero}, 8'h01);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule